// File: doc/BRIEF.md
# Triple Clock Source Divergence Monitor

This block watches three redundant clock sources that together replace one clock generator. Each source clocks its own free-running counter. That counter is held in three copies that vote on every edge, so an upset in one copy is outvoted and then overwritten. Each voted count crosses into a shared monitor clock domain as Gray code through a two-flop synchronizer. In the monitor domain, the three counts are compared in pairs.

When two sources agree and the third disagrees with both of them for long enough, the third source is named as faulty. The block then sends a reset request pulse to that source alone. After the pulse, the faulty source's count is realigned to a healthy one, and a holdoff period follows before any new decision. If every pair disagrees, no source can be singled out. The block raises a separate multiple-fault flag and issues no reset. This block only detects the faulty source and requests its reset; the clock generators themselves are not part of it.

Top module: `clk_trio_monitor`

## Requirements
- R1: While `rst_n` is low, and on the first monitor cycle after it is released, `fault`, `src_rst_req` and `multi_fault` are all zero.
- R2: Three sources running at the same rate, with arbitrary phases, never raise `fault` or `multi_fault`. Two counts agree when their difference, taken modulo 2^CW and made absolute, is at most TOL (default 4).
- R3: When the other two counts agree with each other and disagree with one count, that count's source is flagged. Bit i of `fault` stands for `src_clk[i]`, and at most one bit is ever set. A source that runs too fast and a source whose clock has stopped are both caught.
- R4: A single-source disagreement that lasts fewer than PERSIST (default 8) consecutive monitor cycles raises no flag and no reset request.
- R5: When a fault is declared, `src_rst_req` equals `fault` in that same cycle. It stays equal for exactly PULSE (default 16) monitor cycles and is zero at every other time.
- R6: The `fault` bit stays high for PULSE+HOLDOFF (default 16+64 = 80) monitor cycles and then clears. The flagged source is realigned at the end of the pulse, so if its rate is correct again it raises no further fault.
- R7: When all three pairs disagree for PERSIST consecutive cycles, `multi_fault` goes high. While it is high, `fault` and `src_rst_req` stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 3 | The three redundant source clocks; bit i is source i |
| mon_clk | input | 1 | Monitor domain clock |
| rst_n | input | 1 | Active-low asynchronous reset for all domains |
| fault | output | 3 | One-hot flag naming the faulty source |
| src_rst_req | output | 3 | Reset request pulse for the faulty source only |
| multi_fault | output | 1 | All three sources mutually disagree |

## Verification
The hardest states to reach from the ports are the ones where the clocks themselves must be reshaped in time. The first is a disagreement that is real but shorter than the persistence window. The bench gets there by freezing one source for a few of its periods and then running it at double rate until it catches up. The second is a three-way split. The bench reaches it from reset by running one source at twice the rate and stopping another. With those rates the middle source drifts from both neighbours at equal speed, so both of its pairs break in the same few cycles. A single-source verdict therefore never persists before every pair has disagreed.

// File: rtl/clk_trio_monitor.sv
module clk_trio_monitor #(
  parameter int CW      = 10,
  parameter int TOL     = 4,
  parameter int PERSIST = 8,
  parameter int PULSE   = 16,
  parameter int HOLDOFF = 64
) (
  input  logic [2:0] src_clk,
  input  logic       mon_clk,
  input  logic       rst_n,
  output logic [2:0] fault,
  output logic [2:0] src_rst_req,
  output logic       multi_fault
);
  localparam int TW = $clog2((HOLDOFF > PULSE ? HOLDOFF : PULSE) + 1);
  localparam int PW = $clog2(PERSIST + 1);
  localparam logic [CW-1:0] TOLV = CW'(TOL);
  localparam logic [TW-1:0] PEND = TW'(PULSE - 1);
  localparam logic [TW-1:0] HEND = TW'(HOLDOFF - 1);
  localparam logic [PW-1:0] QEND = PW'(PERSIST - 1);

  typedef enum logic [1:0] {WATCH, PULSING, HOLD} st_t;

  function automatic logic [CW-1:0] g2b(input logic [CW-1:0] x);
    logic [CW-1:0] b;
    b[CW-1] = x[CW-1];
    for (int i = CW - 2; i >= 0; i--) b[i] = b[i+1] ^ x[i];
    return b;
  endfunction

  function automatic logic near(input logic [CW-1:0] x, input logic [CW-1:0] y);
    logic [CW-1:0] d;
    d = x - y;
    if (d[CW-1]) d = -d;
    return d <= TOLV;
  endfunction

  logic [2:0][CW-1:0] bin, adj, off;

  for (genvar g = 0; g < 3; g++) begin : g_src
    logic [CW-1:0] rep [3];
    logic [CW-1:0] vote, nxt, gray, s1, s2;
    assign vote = (rep[0] & rep[1]) | (rep[1] & rep[2]) | (rep[0] & rep[2]);
    assign nxt  = vote + 1'b1;

    always_ff @(posedge src_clk[g] or negedge rst_n) begin
      if (!rst_n) begin
        for (int r = 0; r < 3; r++) rep[r] <= '0;
        gray <= '0;
      end else begin
        for (int r = 0; r < 3; r++) rep[r] <= nxt;
        gray <= nxt ^ (nxt >> 1);
      end
    end

    always_ff @(posedge mon_clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= '0;
        s2 <= '0;
      end else begin
        s1 <= gray;
        s2 <= s1;
      end
    end

    assign bin[g] = g2b(s2);
    assign adj[g] = bin[g] + off[g];
  end

  logic ab, bc, ca, all_bad;
  logic [2:0] odd, held;
  assign ab = near(adj[0], adj[1]);
  assign bc = near(adj[1], adj[2]);
  assign ca = near(adj[2], adj[0]);
  assign odd = {ab & ~bc & ~ca, ca & ~ab & ~bc, bc & ~ab & ~ca};
  assign all_bad = ~ab & ~bc & ~ca;

  st_t st;
  logic [TW-1:0] tmr;
  logic [PW-1:0] pc, mc;

  assign src_rst_req = (st == PULSING) ? fault : 3'b000;

  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= WATCH;
      tmr <= '0;
      pc <= '0;
      mc <= '0;
      held <= '0;
      fault <= '0;
      multi_fault <= 1'b0;
      off <= '0;
    end else begin
      case (st)
        WATCH: begin
          held <= odd;
          if (odd != 3'b000 && odd == held) begin
            if (pc == QEND) begin
              st <= PULSING;
              fault <= odd;
              tmr <= '0;
              pc <= '0;
            end else pc <= pc + 1'b1;
          end else pc <= (odd != 3'b000) ? PW'(1) : '0;
          if (all_bad) begin
            if (mc == QEND) multi_fault <= 1'b1;
            else mc <= mc + 1'b1;
          end else begin
            mc <= '0;
            multi_fault <= 1'b0;
          end
        end
        PULSING: begin
          if (tmr == PEND) begin
            st <= HOLD;
            tmr <= '0;
            for (int i = 0; i < 3; i++)
              if (fault[i]) off[i] <= adj[(i == 0) ? 1 : 0] - bin[i];
          end else tmr <= tmr + 1'b1;
        end
        HOLD: begin
          if (tmr == HEND) begin
            st <= WATCH;
            fault <= '0;
            held <= '0;
            pc <= '0;
          end else tmr <= tmr + 1'b1;
        end
        default: st <= WATCH;
      endcase
    end
  end
endmodule

// File: rtl/clk_trio_monitor_chk.sv
module clk_trio_monitor_chk #(
  parameter int PULSE = 16
) (
  input logic       mon_clk,
  input logic       rst_n,
  input logic [2:0] fault,
  input logic [2:0] src_rst_req,
  input logic       multi_fault
);
  localparam int RW = $clog2(PULSE + 2);
  logic [RW-1:0] rc;

  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) rc <= '0;
    else rc <= (src_rst_req != 3'b000) ? rc + 1'b1 : '0;
  end

  AST_FAULT_ONEHOT: assert property (@(posedge mon_clk) disable iff (!rst_n)
    $onehot0(fault)); // R3
  AST_RST_ONLY_FAULTY: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (src_rst_req != 3'b000) |-> (src_rst_req == fault)); // R5
  AST_RST_AT_ONSET: assert property (@(posedge mon_clk) disable iff (!rst_n)
    $rose(|fault) |-> (src_rst_req == fault)); // R5
  AST_RST_NOT_LONG: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (src_rst_req != 3'b000) |-> (rc < RW'(PULSE))); // R5
  AST_RST_FULL_LEN: assert property (@(posedge mon_clk) disable iff (!rst_n)
    $fell(|src_rst_req) |-> (rc == RW'(PULSE))); // R5
  AST_MULTI_QUIET: assert property (@(posedge mon_clk) disable iff (!rst_n)
    multi_fault |-> (src_rst_req == 3'b000 && fault == 3'b000)); // R7
endmodule

bind clk_trio_monitor clk_trio_monitor_chk #(.PULSE(PULSE)) u_chk (
  .mon_clk(mon_clk),
  .rst_n(rst_n),
  .fault(fault),
  .src_rst_req(src_rst_req),
  .multi_fault(multi_fault)
);

// File: tb/sim_clk_trio_monitor.sv
`timescale 1ns/1ps
module sim_clk_trio_monitor;
  logic mon_clk = 1'b0;
  logic rst_n = 1'b0;
  logic ca = 1'b0, cb = 1'b0, cc = 1'b0;
  real hp_a = 5.0, hp_b = 5.0, hp_c = 5.0;
  logic stop_a = 1'b0, stop_b = 1'b0, stop_c = 1'b0;
  logic [2:0] fault, src_rst_req;
  logic multi_fault;

  int errors = 0, checks = 0, events = 0;

  typedef struct { int kind; int idx; } item_t;
  item_t q[$];

  clk_trio_monitor u0 (
    .src_clk({cc, cb, ca}), .mon_clk(mon_clk), .rst_n(rst_n),
    .fault(fault), .src_rst_req(src_rst_req), .multi_fault(multi_fault)
  );

  always #2.5 mon_clk = ~mon_clk;
  initial begin #0.0; forever begin #(hp_a); if (!stop_a) ca = ~ca; end end
  initial begin #1.3; forever begin #(hp_b); if (!stop_b) cb = ~cb; end end
  initial begin #3.7; forever begin #(hp_c); if (!stop_c) cc = ~cc; end end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge mon_clk);
  endtask

  task automatic push(input int kind, input int idx);
    item_t it;
    it.kind = kind;
    it.idx = idx;
    q.push_back(it);
  endtask

  task automatic wait_sig(input int which);
    for (int i = 0; i < 3000; i++) begin
      @(negedge mon_clk);
      if (which < 3 && fault[which]) break;
      if (which == 3 && multi_fault) break;
    end
  endtask

  // monitor: compares produced events with the expected queue
  initial begin
    forever begin
      @(negedge mon_clk);
      if (rst_n && (fault != 3'b000 || multi_fault)) begin
        item_t exp;
        events++;
        if (q.size() == 0) begin
          chk(0, "R2", "unexpected event, fault", int'(fault), 0);
          exp.kind = -1;
          exp.idx = -1;
        end else exp = q.pop_front();
        if (fault != 3'b000) begin
          int idx, n, m;
          idx = fault[0] ? 0 : (fault[1] ? 1 : 2);
          if (exp.kind >= 0) begin
            chk(exp.kind == 0, "R3", "event kind", 0, exp.kind);
            chk(idx == exp.idx, "R3", "faulty source index", idx, exp.idx);
          end
          n = 0;
          while (fault != 3'b000 && src_rst_req == fault) begin n++; @(negedge mon_clk); end
          chk(n == 16, "R5", "reset pulse cycles", n, 16);
          chk(src_rst_req == 3'b000, "R5", "request after pulse", int'(src_rst_req), 0);
          m = n;
          while (fault != 3'b000) begin m++; @(negedge mon_clk); end
          chk(m == 80, "R6", "fault flag cycles", m, 80);
        end else begin
          int bad = 0;
          if (exp.kind >= 0) chk(exp.kind == 1, "R7", "event kind", 1, exp.kind);
          while (multi_fault && rst_n) begin
            if (src_rst_req != 3'b000 || fault != 3'b000) bad++;
            @(negedge mon_clk);
          end
          chk(bad == 0, "R7", "cycles with reset or fault during multi", bad, 0);
        end
      end
    end
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cycles(5);
    chk(fault == 0 && src_rst_req == 0 && !multi_fault, "R1", "outputs in reset",
        int'({multi_fault, src_rst_req, fault}), 0);
    rst_n = 1'b1;
    cycles(1);
    chk(fault == 0 && src_rst_req == 0 && !multi_fault, "R1", "outputs after release",
        int'({multi_fault, src_rst_req, fault}), 0);

    // R2: equal rates, different phases
    cycles(3000);
    chk(events == 0, "R2", "events with healthy sources", events, 0);

    // R3: source 1 runs fast
    push(0, 1);
    hp_b = 3.5;
    wait_sig(1);
    chk(fault[1] == 1'b1, "R3", "fast source flagged", int'(fault), 2);
    hp_b = 5.0;
    cycles(300);
    chk(events == 1, "R3", "events after fast source", events, 1);
    cycles(2000);
    chk(events == 1 && fault == 0, "R6", "no refault after realignment", events, 1);

    // R4: short disagreement below persistence
    stop_c = 1'b1;
    #50;
    hp_c = 2.5;
    stop_c = 1'b0;
    #50;
    hp_c = 5.0;
    cycles(1000);
    chk(events == 1 && fault == 0, "R4", "brief divergence ignored", events, 1);

    // R3: source 2 stuck
    push(0, 2);
    stop_c = 1'b1;
    wait_sig(2);
    chk(fault[2] == 1'b1, "R3", "stopped source flagged", int'(fault), 4);
    stop_c = 1'b0;
    cycles(300);
    chk(events == 2, "R3", "events after stopped source", events, 2);
    cycles(1500);
    chk(events == 2 && fault == 0, "R6", "stopped source realigned", events, 2);

    // R7: three-way split from reset
    rst_n = 1'b0;
    hp_a = 5.0;
    hp_b = 2.5;
    stop_c = 1'b1;
    cycles(5);
    push(1, 0);
    rst_n = 1'b1;
    wait_sig(3);
    chk(multi_fault == 1'b1, "R7", "multi flag raised", int'(multi_fault), 1);
    cycles(200);
    chk(multi_fault == 1'b1 && src_rst_req == 0, "R7", "multi held without reset",
        int'({multi_fault, src_rst_req}), 8);
    rst_n = 1'b0;
    cycles(5);
    chk(fault == 0 && src_rst_req == 0 && !multi_fault, "R1", "outputs cleared by reset",
        int'({multi_fault, src_rst_req, fault}), 0);
    chk(events == 3, "R7", "total events", events, 3);
    chk(q.size() == 0, "R3", "expected items left", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule